// File: doc/BRIEF.md
# Per-Drive IDE Strobe Timing Generator

This block sits on the host side of a parallel ATA channel. It produces the read/write strobe for programmed-I/O and multiword-DMA accesses. It keeps one 32-bit timing word for each of the two drives on the channel. A built-in encoder turns a PIO mode (0..4) and/or a multiword-DMA mode (0..2) into that word when software writes a drive's configuration.

When an access starts, the block chooses one stored word and latches it as the active word. The active word stays frozen until the access has finished. During the access the strobe is held high for the active tick count. It is then held low for the inactive tick count plus a fixed recovery offset. Only after that can another access begin. The ceiling-rounded tick is 30 ns.

Top module: `ide_strobe_timer`

## Requirements
- R1: After reset, `strobe`, `busy` and `act_word` are 0, and both stored words are 0.
- R2: The PIO part of a word is built as follows. The active ticks are ceil(active_ns/30), with a minimum of 1, placed in bits [4:0]. The inactive ticks are ceil(cycle_ns/30) minus the active ticks minus 4, with a minimum of 1, placed in bits [10:5]. The (cycle, active) times in ns are 600/180, 390/150, 240/105, 180/90 and 120/75 for modes 0 to 4. The resulting words are 0x146, 0x085, 0x024, 0x023 and 0x023.
- R3: The DMA part of a word is built as follows. The active ticks are ceil(active_ns/30), placed in bits [15:11]. The inactive ticks are cycle ticks minus active ticks minus 1, with a minimum of 1, placed in bits [20:16]. The times are 480/240, 165/90 and 120/75 for modes 0 to 2, giving 0x74000, 0x21800 and 0x11800. Bit 21 and bits [31:22] are always 0.
- R4: A disabled part (PIO or DMA) contributes zero bits to the word. A PIO mode above 4 encodes as mode 4, and a DMA mode above 2 encodes as mode 2.
- R5: If `acc_req` is sampled high while `busy` is low, `strobe` is high starting in the next cycle. It stays high for the active field of the latched word, using the PIO field when `acc_dma`=0 and the DMA field when `acc_dma`=1. An active field of 0 counts as 1.
- R6: After the strobe falls, `busy` stays high with `strobe` low for the inactive field plus 4 cycles (PIO) or plus 1 cycle (DMA), and then falls. `acc_req` is ignored while `busy` is high.
- R7: At access start, the word latched is the word of `sel_drive`. If that word is zero, the block takes drive 0's word if it is nonzero, and otherwise drive 1's word.
- R8: `act_word` does not change while an access is in progress. A configuration write or a change of `sel_drive` during an access takes effect only at the next access start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write the encoded word into the stored word of `cfg_drive` |
| cfg_drive | input | 1 | Drive whose word is written |
| cfg_pio_en | input | 1 | Include PIO timing in the word |
| cfg_pio_mode | input | 3 | PIO mode 0..4 |
| cfg_dma_en | input | 1 | Include multiword-DMA timing in the word |
| cfg_dma_mode | input | 2 | Multiword-DMA mode 0..2 |
| sel_drive | input | 1 | Currently selected drive |
| acc_req | input | 1 | Request to start an access |
| acc_dma | input | 1 | Access kind: 0 PIO, 1 DMA |
| strobe | output | 1 | Read/write strobe, active high |
| busy | output | 1 | Access in progress (strobe or recovery) |
| act_word | output | 32 | Timing word latched for the current or last access |

## Verification
The in-module assertions check four properties on every cycle. Every access opens with the strobe high. The strobe always falls into at least one recovery cycle. The active word never moves while an access runs. Bit 21 of the active word is always clear. What only the bench scenarios can show is the following. The encoded tick values for each mode. The exact widths of the strobe and recovery phases. The fallback order between the two drives' words. That requests and configuration changes arriving mid-access are deferred to the next access.

// File: rtl/ide_strobe_timer.sv
module ide_strobe_timer #(
  parameter int TICK_NS = 30,
  parameter int PIO_REC = 4,
  parameter int DMA_REC = 1,
  parameter int CW      = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_drive,
  input  logic        cfg_pio_en,
  input  logic [2:0]  cfg_pio_mode,
  input  logic        cfg_dma_en,
  input  logic [1:0]  cfg_dma_mode,
  input  logic        sel_drive,
  input  logic        acc_req,
  input  logic        acc_dma,
  output logic        strobe,
  output logic        busy,
  output logic [31:0] act_word
);

  typedef enum logic [1:0] {IDLE, ACT, REC} phase_t;

  function automatic int ticks(input int ns);
    return (ns + TICK_NS - 1) / TICK_NS;
  endfunction

  function automatic logic [10:0] pio_fields(input logic [2:0] m);
    int c, a, i;
    case (m)
      3'd0:    begin c = ticks(600); a = ticks(180); end
      3'd1:    begin c = ticks(390); a = ticks(150); end
      3'd2:    begin c = ticks(240); a = ticks(105); end
      3'd3:    begin c = ticks(180); a = ticks(90);  end
      default: begin c = ticks(120); a = ticks(75);  end
    endcase
    if (a < 1) a = 1;
    i = c - a - PIO_REC;
    if (i < 1) i = 1;
    return {i[5:0], a[4:0]};
  endfunction

  function automatic logic [9:0] dma_fields(input logic [1:0] m);
    int c, a, i;
    case (m)
      2'd0:    begin c = ticks(480); a = ticks(240); end
      2'd1:    begin c = ticks(165); a = ticks(90);  end
      default: begin c = ticks(120); a = ticks(75);  end
    endcase
    i = c - a - DMA_REC;
    if (i < 1) i = 1;
    return {i[4:0], a[4:0]};
  endfunction

  logic [31:0] words [2];
  logic [31:0] new_word, sel_w, pick;
  logic [4:0]  act_n;
  logic [CW-1:0] act_len, rec_len, cnt;
  logic        kind;
  phase_t      phase;

  assign new_word = {11'd0,
                     cfg_dma_en ? dma_fields(cfg_dma_mode) : 10'd0,
                     cfg_pio_en ? pio_fields(cfg_pio_mode) : 11'd0};

  assign sel_w   = words[sel_drive];
  assign pick    = (sel_w != 0) ? sel_w : ((words[0] != 0) ? words[0] : words[1]);
  assign act_n   = acc_dma ? pick[15:11] : pick[4:0];
  assign act_len = (act_n == 0) ? CW'(1) : CW'(act_n);
  assign rec_len = kind ? CW'(act_word[20:16]) + CW'(DMA_REC)
                        : CW'(act_word[10:5]) + CW'(PIO_REC);

  assign strobe = (phase == ACT);
  assign busy   = (phase != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words[0] <= '0;
      words[1] <= '0;
      act_word <= '0;
      kind     <= 1'b0;
      cnt      <= '0;
      phase    <= IDLE;
    end else begin
      if (cfg_we) words[cfg_drive] <= new_word;
      case (phase)
        IDLE: if (acc_req) begin
          act_word <= pick;
          kind     <= acc_dma;
          cnt      <= act_len - CW'(1);
          phase    <= ACT;
        end
        ACT: if (cnt == 0) begin
          cnt   <= rec_len - CW'(1);
          phase <= REC;
        end else cnt <= cnt - CW'(1);
        REC: if (cnt == 0) phase <= IDLE;
             else cnt <= cnt - CW'(1);
        default: phase <= IDLE;
      endcase
    end
  end

  // R5
  start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> strobe);

  // R6
  recovery_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> busy);

  // R6
  end_after_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(strobe));

  // R8
  word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(act_word));

  // R3
  half_tick_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_word[21]);

endmodule

// File: tb/sim_ide_strobe_timer.sv
module sim_ide_strobe_timer;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_drive = 0, cfg_pio_en = 0, cfg_dma_en = 0;
  logic [2:0] cfg_pio_mode = 0;
  logic [1:0] cfg_dma_mode = 0;
  logic sel_drive = 0, acc_req = 0, acc_dma = 0;
  logic strobe, busy;
  logic [31:0] act_word;

  int nvec = 0, nfail = 0;

  always #5 clk = ~clk;

  ide_strobe_timer u0 (.*);

  int pio_cyc [5] = '{600, 390, 240, 180, 120};
  int pio_act [5] = '{180, 150, 105, 90, 75};
  int dma_cyc [3] = '{480, 165, 120};
  int dma_act [3] = '{240, 90, 75};

  function automatic int cdiv(int ns); return (ns + 29) / 30; endfunction

  function automatic int ref_word(bit pe, int pm, bit de, int dm);
    int w = 0, a, i;
    if (pm > 4) pm = 4;
    if (dm > 2) dm = 2;
    if (pe) begin
      a = cdiv(pio_act[pm]); if (a < 1) a = 1;
      i = cdiv(pio_cyc[pm]) - a - 4; if (i < 1) i = 1;
      w += i * 32 + a;
    end
    if (de) begin
      a = cdiv(dma_act[dm]);
      i = cdiv(dma_cyc[dm]) - a - 1; if (i < 1) i = 1;
      w += i * 65536 + a * 2048;
    end
    return w;
  endfunction

  // behavioural reference
  int m_words [2];
  int m_act = 0, m_phase = 0, m_left = 0;
  bit m_dma = 0;

  always @(posedge clk) begin
    int p, a, r;
    if (!rst_n) begin
      m_words[0] = 0; m_words[1] = 0; m_act = 0; m_phase = 0; m_left = 0; m_dma = 0;
    end else begin
      if (m_phase == 0) begin
        if (acc_req) begin
          p = m_words[sel_drive];
          if (p == 0) p = (m_words[0] != 0) ? m_words[0] : m_words[1];
          m_act = p; m_dma = acc_dma;
          a = acc_dma ? (p >> 11) % 32 : p % 32;
          m_left = (a == 0) ? 1 : a;
          m_phase = 1;
        end
      end else if (m_phase == 1) begin
        m_left--;
        if (m_left == 0) begin
          r = m_dma ? (m_act >> 16) % 32 + 1 : (m_act >> 5) % 64 + 4;
          m_left = r; m_phase = 2;
        end
      end else begin
        m_left--;
        if (m_left == 0) m_phase = 0;
      end
      if (cfg_we)
        m_words[cfg_drive] = ref_word(cfg_pio_en, cfg_pio_mode, cfg_dma_en, cfg_dma_mode);
    end
  end

  always @(negedge clk) if (rst_n) begin
    nvec++;
    // R5 R6 strobe and busy timing, R7 R8 latched word
    if (strobe !== (m_phase == 1) || busy !== (m_phase != 0) || act_word !== 32'(m_act)) begin
      nfail++;
      $display("FAIL R5 R6 R7 R8 cycle compare: strobe=%b busy=%b word=%h exp strobe=%b busy=%b word=%h",
               strobe, busy, act_word, m_phase == 1, m_phase != 0, m_act);
    end
  end

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(bit d, bit pe, int pm, bit de, int dm);
    @(negedge clk);
    cfg_we = 1; cfg_drive = d; cfg_pio_en = pe; cfg_pio_mode = 3'(pm);
    cfg_dma_en = de; cfg_dma_mode = 2'(dm);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // runs one access; pokes a request and a config change mid-access when asked
  task automatic access(bit dma, bit poke, output int hi, output int tot);
    @(negedge clk);
    acc_req = 1; acc_dma = dma;
    @(negedge clk);
    acc_req = 0;
    hi = 0; tot = 0;
    while (busy && tot < 200) begin
      if (strobe) hi++;
      tot++;
      if (poke && tot == 2) begin
        acc_req = 1; cfg_we = 1; cfg_drive = sel_drive; cfg_pio_en = 0; cfg_dma_en = 0;
        sel_drive = ~sel_drive;
      end
      if (poke && tot == 3) begin acc_req = 0; cfg_we = 0; end
      @(negedge clk);
    end
  endtask

  initial begin
    int hi, tot;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 strobe", strobe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 act_word", act_word, 0);
    rst_n = 1;

    // R5 zero word: active counts as 1, recovery 0+4
    access(0, 0, hi, tot);
    chk("R5 zero-field strobe width", hi, 1);
    chk("R6 zero-field busy length", tot, 5);

    // R2 PIO mode 0 on drive 0
    wr(0, 1, 0, 0, 0);
    sel_drive = 0;
    access(0, 0, hi, tot);
    chk("R2 pio mode0 word", act_word, 32'h146);
    chk("R5 pio mode0 strobe", hi, 6);
    chk("R6 pio mode0 busy", tot, 20);

    // R2 all PIO modes
    for (int m = 0; m < 5; m++) begin
      wr(1, 1, m, 0, 0);
      sel_drive = 1;
      access(0, 0, hi, tot);
      chk("R2 pio word", act_word, ref_word(1, m, 0, 0));
    end
    chk("R2 pio mode2 literal", ref_word(1, 2, 0, 0), 32'h024);

    // R3 DMA mode 1 on drive 1
    wr(1, 0, 0, 1, 1);
    access(1, 0, hi, tot);
    chk("R3 dma mode1 word", act_word, 32'h21800);
    chk("R5 dma mode1 strobe", hi, 3);
    chk("R6 dma mode1 busy", tot, 6);
    for (int m = 0; m < 3; m++) begin
      wr(1, 0, 0, 1, m);
      access(1, 0, hi, tot);
      chk("R3 dma word", act_word, ref_word(0, 0, 1, m));
    end

    // R4 out-of-range modes and combined parts
    wr(0, 1, 7, 1, 3);
    sel_drive = 0;
    access(0, 0, hi, tot);
    chk("R4 clamped word", act_word, 32'h11823);
    chk("R6 pio recovery +4", tot - hi, 5);
    access(1, 0, hi, tot);
    chk("R6 dma recovery +1", tot - hi, 2);
    wr(0, 0, 1, 1, 0);
    access(1, 0, hi, tot);
    chk("R4 pio disabled", act_word, 32'h74000);

    // R7 fallback order
    wr(0, 1, 0, 0, 0);
    wr(1, 0, 0, 0, 0);
    sel_drive = 1;
    access(0, 0, hi, tot);
    chk("R7 fallback to drive0", act_word, 32'h146);
    wr(0, 0, 0, 0, 0);
    wr(1, 0, 0, 1, 1);
    sel_drive = 0;
    access(1, 0, hi, tot);
    chk("R7 fallback to drive1", act_word, 32'h21800);

    // R8 and R6: mid-access request, config write and select change deferred
    wr(0, 1, 0, 0, 0);
    sel_drive = 0;
    access(0, 1, hi, tot);
    chk("R8 word held", act_word, 32'h146);
    chk("R6 request ignored while busy", tot, 20);
    chk("R6 no restart after", busy, 0);
    access(0, 0, hi, tot);
    chk("R8 next access sees change", act_word, 32'h21800);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule